// File: doc/BRIEF.md
# SPI Slave Framing and Ones-Run Resynchronisation

This block is the front end of an SPI slave. Chip select (active low) frames each transaction. A small protocol state machine records whether the slave is waiting for an instruction, is inside a transaction, or is streaming. The instruction decoder next to this block reports when an instruction begins, when it completes, and when streaming is entered. Chip select may be tied low for good on a bus with a single slave, so the block also offers a second way to regain protocol sync. When that feature is enabled, a long unbroken run of ones on the serial data input returns the state machine to idle. The same event clears the upper-address pointer. No other register contents change.

All logic runs on the rising edge of the serial clock, with an asynchronous active-low system reset. Chip select is therefore acted on at the next SCLK rising edge. The enable register sits behind a plain register-write port, which the register decoder drives in the same clock domain. The block has no data stream of its own: every pin is a plain control or status pin, and there is no valid/ready handshake and no back-pressure. Streaming can only be ended by chip select going high. Software must not enter streaming while chip select is tied low.

Top module: `spi_frame_sync`

## Requirements
- R1: While rst_n is low, the block is held in its reset state: the enable bit is 0, upper_addr is 0, proto_state is IDLE (2'd0), instr_armed is 1 and proto_rst is 0.
- R2: A write on the register port (reg_wr_en high at an SCLK rising edge) to address 0x02 loads bit 0 of reg_wr_data into the enable bit. The new value applies from the next edge. A write to any other address leaves the enable bit unchanged. Writing 0x01 enables the feature and writing 0x00 disables it.
- R3: While the enable bit is 0, proto_rst stays 0 whatever the data on sdi.
- R4: Three conditions apply: the feature is enabled, csb_n is low and the state is not STREAM. Under them, the rising edge that samples the 73rd consecutive 1 on sdi drives proto_rst high for exactly the SCLK cycle that follows it. A run of 72 ones followed by a zero produces no pulse.
- R5: Any 0 sampled on sdi restarts the run count. A run longer than 73 ones produces only one pulse, because the count saturates and cannot wrap.
- R6: At the edge that causes a ones-run reset, upper_addr becomes 0 and proto_state becomes IDLE. The enable bit keeps its value.
- R7: csb_n high at an SCLK rising edge sends proto_state to IDLE and clears the run count. Ones sampled before a high csb_n therefore do not add to a later run.
- R8: With csb_n low, the state moves in four ways. IDLE goes to BUSY (2'd1) on txn_begin. BUSY goes back to IDLE on txn_done. IDLE or BUSY goes to STREAM (2'd2) on stream_begin. STREAM is left only when csb_n goes high. In STREAM, ones on sdi never produce a reset. instr_armed is 1 exactly when the state is IDLE.
- R9: ura_wr_en loads ura_wr_data into upper_addr at an SCLK rising edge. If a ones-run reset happens at the same edge, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low system reset |
| csb_n | input | 1 | Chip select, active low; frames transactions |
| sdi | input | 1 | Serial data input, watched for ones runs |
| reg_wr_en | input | 1 | Register-write strobe |
| reg_wr_addr | input | 8 | Register-write address |
| reg_wr_data | input | 8 | Register-write data |
| ura_wr_en | input | 1 | Load strobe for the upper-address pointer |
| ura_wr_data | input | 3 | Value to load into the upper-address pointer |
| txn_begin | input | 1 | Decoder has started an instruction |
| txn_done | input | 1 | Decoder has completed an instruction |
| stream_begin | input | 1 | Decoder is entering streaming |
| proto_rst | output | 1 | One-cycle pulse after a ones-run reset |
| upper_addr | output | 3 | Current upper-address pointer |
| proto_state | output | 2 | Protocol state: 0 IDLE, 1 BUSY, 2 STREAM |
| instr_armed | output | 1 | High when the next edge may start an instruction |

## Verification
The run detector is driven with five kinds of sdi pattern:
- A run of exactly 73 ones, which places the pulse on its cycle.
- A run of 72 ones broken by a zero, which separates a correct threshold from an off-by-one.
- A run of several hundred ones, which tells a saturating count from one that wraps and fires again.
- A run split by a single high cycle on chip select.
- A run sent during streaming.

The run of 73 is also sent with the feature disabled, after a write to the wrong address, and right after a system reset. These cases show that the enable bit gates the detector and that reset clears the bit. Finally, a run sent from the busy state with a loaded upper-address pointer shows that the pointer and the state are cleared while the enable bit survives.

// File: rtl/spi_fs_pkg.sv
package spi_fs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_BUSY   = 2'd1,
    ST_STREAM = 2'd2
  } proto_st_e;

  localparam int unsigned REG_AW   = 8;
  localparam int unsigned REG_DW   = 8;
  localparam logic [REG_AW-1:0] CFG_ADDR = 8'h02;
endpackage

// File: rtl/spi_fs_cfg.sv
module spi_fs_cfg
  import spi_fs_pkg::*;
(
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [REG_DW-1:0] wr_data,
  output logic              run_en
);
  logic hit;
  assign hit = wr_en && (wr_addr == CFG_ADDR);

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n)   run_en <= 1'b0;
    else if (hit) run_en <= wr_data[0];
  end

  // R2
  other_addr_ignored_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    (wr_en && wr_addr != CFG_ADDR) |=> $stable(run_en));
endmodule

// File: rtl/spi_fs_ones_cnt.sv
module spi_fs_ones_cnt #(
  parameter int unsigned RUN_LEN = 73
) (
  input  logic sclk,
  input  logic rst_n,
  input  logic count_ok,
  input  logic sdi,
  output logic fire,
  output logic pulse
);
  localparam int unsigned CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] SAT  = CW'(RUN_LEN);
  localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

  logic [CW-1:0] cnt_q;

  assign fire = count_ok && sdi && (cnt_q == LAST);

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= fire;
      if (!count_ok || !sdi) cnt_q <= '0;
      else if (cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
    end
  end

  // R5
  single_pulse_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    pulse |=> !pulse);
  // R4
  pulse_cause_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    pulse |-> $past(count_ok && sdi));
endmodule

// File: rtl/spi_fs_proto_fsm.sv
module spi_fs_proto_fsm
  import spi_fs_pkg::*;
#(
  parameter int unsigned URA_W = 3
) (
  input  logic             sclk,
  input  logic             rst_n,
  input  logic             csb_n,
  input  logic             ones_fire,
  input  logic             txn_begin,
  input  logic             txn_done,
  input  logic             stream_begin,
  input  logic             ura_wr_en,
  input  logic [URA_W-1:0] ura_wr_data,
  output proto_st_e        state,
  output logic [URA_W-1:0] ura
);
  proto_st_e nxt;

  always_comb begin
    nxt = state;
    if (csb_n || ones_fire) nxt = ST_IDLE;
    else begin
      unique case (state)
        ST_IDLE:   if (stream_begin) nxt = ST_STREAM;
                   else if (txn_begin) nxt = ST_BUSY;
        ST_BUSY:   if (stream_begin) nxt = ST_STREAM;
                   else if (txn_done) nxt = ST_IDLE;
        ST_STREAM: nxt = ST_STREAM;
        default:   nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      ura   <= '0;
    end else begin
      state <= nxt;
      if (ones_fire)      ura <= '0;
      else if (ura_wr_en) ura <= ura_wr_data;
    end
  end

  // R8
  stream_hold_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    (state == ST_STREAM && !csb_n) |=> state == ST_STREAM);
  // R7
  csb_idle_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    csb_n |=> state == ST_IDLE);
endmodule

// File: rtl/spi_frame_sync.sv
module spi_frame_sync
  import spi_fs_pkg::*;
#(
  parameter int unsigned RUN_LEN = 73,
  parameter int unsigned URA_W   = 3
) (
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              csb_n,
  input  logic              sdi,
  input  logic              reg_wr_en,
  input  logic [REG_AW-1:0] reg_wr_addr,
  input  logic [REG_DW-1:0] reg_wr_data,
  input  logic              ura_wr_en,
  input  logic [URA_W-1:0]  ura_wr_data,
  input  logic              txn_begin,
  input  logic              txn_done,
  input  logic              stream_begin,
  output logic              proto_rst,
  output logic [URA_W-1:0]  upper_addr,
  output logic [1:0]        proto_state,
  output logic              instr_armed
);
  logic      run_en, count_ok, fire;
  proto_st_e st;

  assign count_ok    = run_en && !csb_n && (st != ST_STREAM);
  assign proto_state = st;
  assign instr_armed = (st == ST_IDLE);

  spi_fs_cfg u_cfg (
    .sclk(sclk), .rst_n(rst_n), .wr_en(reg_wr_en),
    .wr_addr(reg_wr_addr), .wr_data(reg_wr_data), .run_en(run_en)
  );

  spi_fs_ones_cnt #(.RUN_LEN(RUN_LEN)) u_cnt (
    .sclk(sclk), .rst_n(rst_n), .count_ok(count_ok), .sdi(sdi),
    .fire(fire), .pulse(proto_rst)
  );

  spi_fs_proto_fsm #(.URA_W(URA_W)) u_fsm (
    .sclk(sclk), .rst_n(rst_n), .csb_n(csb_n), .ones_fire(fire),
    .txn_begin(txn_begin), .txn_done(txn_done), .stream_begin(stream_begin),
    .ura_wr_en(ura_wr_en), .ura_wr_data(ura_wr_data),
    .state(st), .ura(upper_addr)
  );

  // R3
  disabled_quiet_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    !run_en |=> !proto_rst);
  // R6
  ura_cleared_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    proto_rst |-> (upper_addr == '0 && instr_armed));
  // R6
  enable_kept_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    proto_rst |-> run_en);
endmodule

// File: tb/spi_frame_sync_tb.sv
module spi_frame_sync_tb;
  localparam int CLK_PERIOD = 10;

  logic       sclk = 1'b0, rst_n = 1'b0, csb_n = 1'b1, sdi = 1'b0;
  logic       reg_wr_en = 1'b0, ura_wr_en = 1'b0;
  logic [7:0] reg_wr_addr = '0, reg_wr_data = '0;
  logic [2:0] ura_wr_data = '0;
  logic       txn_begin = 1'b0, txn_done = 1'b0, stream_begin = 1'b0;
  logic       proto_rst, instr_armed;
  logic [2:0] upper_addr;
  logic [1:0] proto_state;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) sclk = ~sclk;

  spi_frame_sync u_dut (
    .sclk(sclk), .rst_n(rst_n), .csb_n(csb_n), .sdi(sdi),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .ura_wr_en(ura_wr_en), .ura_wr_data(ura_wr_data),
    .txn_begin(txn_begin), .txn_done(txn_done), .stream_begin(stream_begin),
    .proto_rst(proto_rst), .upper_addr(upper_addr),
    .proto_state(proto_state), .instr_armed(instr_armed)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one SCLK cycle: inputs set after a falling edge, outputs sampled at the next one
  task automatic cyc();
    @(negedge sclk);
  endtask

  // send n copies of v on sdi; return pulse count and cycle index of first pulse
  task automatic send(input int n, input logic v, output int pulses, output int first);
    pulses = 0; first = -1;
    for (int k = 1; k <= n; k++) begin
      sdi = v; cyc();
      if (proto_rst) begin
        pulses++;
        if (first < 0) first = k;
      end
    end
    sdi = 1'b0;
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [7:0] d);
    reg_wr_en = 1; reg_wr_addr = a; reg_wr_data = d; sdi = 0;
    cyc();
    reg_wr_en = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; csb_n = 1; sdi = 0;
    cyc(); cyc();
    rst_n = 1; csb_n = 0;
    cyc();
  endtask

  task automatic t_reset_state();
    rst_n = 0;
    cyc();
    chk(proto_rst == 0, "R1 proto_rst", proto_rst, 0);
    chk(upper_addr == 0, "R1 upper_addr", upper_addr, 0);
    chk(proto_state == 0, "R1 proto_state", proto_state, 0);
    chk(instr_armed == 1, "R1 instr_armed", instr_armed, 1);
    rst_n = 1; csb_n = 0; cyc();
  endtask

  task automatic t_disabled();
    int p, f;
    ura_wr_en = 1; ura_wr_data = 3'd5; cyc(); ura_wr_en = 0;
    send(100, 1, p, f);
    chk(p == 0, "R3 no pulse while disabled", p, 0);
    chk(upper_addr == 5, "R3 upper_addr kept", upper_addr, 5);
    chk(upper_addr == 5, "R9 ura load", upper_addr, 5);
  endtask

  task automatic t_enable_addr();
    int p, f;
    reg_wr(8'h03, 8'h01);
    send(80, 1, p, f);
    chk(p == 0, "R2 wrong address ignored", p, 0);
    reg_wr(8'h02, 8'h01);
    send(73, 1, p, f);
    chk(p == 1 && f == 73, "R2 enable at 0x02", f, 73);
    sdi = 0; cyc();
  endtask

  task automatic t_threshold();
    int p, f;
    send(72, 1, p, f);
    chk(p == 0, "R4 72 ones no pulse", p, 0);
    send(1, 0, p, f);
    send(72, 1, p, f);
    chk(p == 0, "R5 zero restarts run", p, 0);
    send(1, 1, p, f);
    chk(p == 1, "R4 73rd one pulses", p, 1);
    send(1, 1, p, f);
    chk(p == 0, "R4 pulse one cycle", p, 0);
    send(400, 1, p, f);
    chk(p == 0, "R5 saturate no second pulse", p, 0);
    send(1, 0, p, f);
    send(73, 1, p, f);
    chk(p == 1 && f == 73, "R5 new run pulses again", f, 73);
  endtask

  task automatic t_clear();
    int p, f;
    sdi = 0;
    ura_wr_en = 1; ura_wr_data = 3'd6; txn_begin = 1; cyc();
    ura_wr_en = 0; txn_begin = 0;
    chk(proto_state == 1, "R8 IDLE to BUSY", proto_state, 1);
    chk(instr_armed == 0, "R8 armed low in BUSY", instr_armed, 0);
    for (int k = 1; k <= 73; k++) begin
      sdi = 1;
      if (k == 73) begin ura_wr_en = 1; ura_wr_data = 3'd7; end
      cyc();
    end
    ura_wr_en = 0; sdi = 0;
    chk(proto_rst == 1, "R6 pulse from BUSY", proto_rst, 1);
    chk(upper_addr == 0, "R9 clear beats load", upper_addr, 0);
    chk(proto_state == 0, "R6 state IDLE", proto_state, 0);
    cyc();
    send(73, 1, p, f);
    chk(p == 1, "R6 enable kept", p, 1);
    sdi = 0; txn_begin = 1; cyc(); txn_begin = 0;
    txn_done = 1; cyc(); txn_done = 0;
    chk(proto_state == 0, "R8 BUSY to IDLE", proto_state, 0);
  endtask

  task automatic t_csb();
    int p, f;
    txn_begin = 1; cyc(); txn_begin = 0;
    send(50, 1, p, f);
    csb_n = 1; sdi = 1; cyc();
    chk(proto_state == 0, "R7 csb high gives IDLE", proto_state, 0);
    csb_n = 0;
    send(30, 1, p, f);
    chk(p == 0, "R7 run cleared by csb", p, 0);
    send(43, 1, p, f);
    chk(p == 1 && f == 43, "R7 fresh run after csb", f, 43);
  endtask

  task automatic t_stream();
    int p, f;
    sdi = 0; stream_begin = 1; cyc(); stream_begin = 0;
    chk(proto_state == 2, "R8 enter STREAM", proto_state, 2);
    send(100, 1, p, f);
    chk(p == 0, "R8 no reset in STREAM", p, 0);
    chk(proto_state == 2, "R8 STREAM held", proto_state, 2);
    csb_n = 1; cyc(); csb_n = 0;
    chk(proto_state == 0, "R8 csb leaves STREAM", proto_state, 0);
  endtask

  task automatic t_reset_enable();
    int p, f;
    do_reset();
    send(80, 1, p, f);
    chk(p == 0, "R1 reset clears enable", p, 0);
    reg_wr(8'h02, 8'h01);
    reg_wr(8'h02, 8'h00);
    send(80, 1, p, f);
    chk(p == 0, "R2 write 0x00 disables", p, 0);
  endtask

  initial begin
    cyc();
    t_reset_state();
    t_disabled();
    t_enable_addr();
    t_threshold();
    t_clear();
    t_csb();
    t_stream();
    t_reset_enable();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule